// File: doc/BRIEF.md
# Receive Character Queue with Qualified Flush

This block is a synchronous first-in, first-out queue for 10-bit characters. A receive datapath pushes decoded characters into it through a write strobe. A host pops them with a read enable and sees the oldest stored character on the read data bus. Empty and full flags tell both sides whether they may move data.

The queue can be flushed by the host through an active-low flush request. The request is not acted on at once. It must be sampled low on seven consecutive clocks. On each of those clocks the queue must not be marked as bypassed, the host must not be reading, and the active-low host select must be asserted. When the seventh qualifying sample is taken, the contents are discarded and the empty flag rises.

The queue then stays flushed for as long as the request is held low, and it refuses incoming characters during that time. Empty remains set after the request is released, until a new character is written. While the surrounding datapath has the queue marked as bypassed, flush requests are ignored.

Top module: `rxq_fifo`

## Requirements
- R1: After the system reset (`rst_n` low), `empty` is 1 and `full` is 0.
- R2: Characters leave in the order they were written. `rd_data` always shows the oldest stored character while `empty` is 0. A read and a write in the same cycle on a non-empty, non-full queue both take effect.
- R3: The queue holds 16 characters. `full` is 1 exactly when 16 are stored. A write while `full` is 1 is dropped, even when a read happens in the same cycle. `empty` and `full` are never 1 together.
- R4: A read while `empty` is 1 is ignored and moves no pointer. A write in that same cycle is still stored.
- R5: A flush starts on the clock edge that takes the seventh consecutive qualifying sample. A sample qualifies when `flush_req_n`=0, `bypass`=0, `rd_en`=0 and `host_sel_n`=0. After six such samples, nothing has changed.
- R6: A sample that does not qualify restarts the count from zero. This covers `flush_req_n` high, `host_sel_n` high or `rd_en` high. A flush then needs seven fresh consecutive qualifying samples.
- R7: When a flush starts, all stored characters are discarded, `empty` goes to 1 and `full` goes to 0 after that same edge.
- R8: While `flush_req_n` stays low after a flush has started, writes are rejected and `empty` stays 1.
- R9: After `flush_req_n` returns high, `empty` stays 1 until the next write. That write is then stored and shown on `rd_data`.
- R10: While `bypass` is 1, `flush_req_n` has no effect, however long it is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register changes on its rising edge |
| rst_n | input | 1 | Asynchronous system reset, active low |
| wr_en | input | 1 | Write strobe from the receive datapath |
| wr_data | input | 10 | Character to store |
| rd_en | input | 1 | Read enable from the host; pops the oldest character |
| rd_data | output | 10 | Oldest stored character (valid while empty is 0) |
| empty | output | 1 | No character is stored |
| full | output | 1 | All 16 entries are occupied |
| host_sel_n | input | 1 | Host select, active low; must be low for a flush sample to qualify |
| bypass | input | 1 | Queue bypassed by the datapath; flush requests ignored while 1 |
| flush_req_n | input | 1 | Flush request, active low |

## Verification
The queue's ordering is tried with single pushes and pops, with a simultaneous push and pop in the middle of the stream, and with pops and push-plus-pop on an empty queue. Together these separate correct show-ahead ordering from off-by-one pointer errors and from reads that underflow. A fill to 16 followed by a dropped write and a complete drain tells a correct full boundary from one that overwrites the oldest entry.

The flush qualifier is driven with exactly six and then seven qualifying samples. It is also driven with runs of six, each broken in turn by a high request, a deselected host and a read, and then followed by six more. These runs show whether the counter restarts and whether it fires one cycle early or late. A long request held under bypass shows that the gate really blocks the flush.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DATA_W      = 10;
    localparam int unsigned RXQ_DEPTH       = 16;
    localparam int unsigned RXQ_QUAL_CYCLES = 7;

    // Flush qualifier states
    typedef enum logic [1:0] {
        QUAL_IDLE = 2'd0,   // no qualifying sample pending
        QUAL_ARM  = 2'd1,   // counting consecutive qualifying samples
        QUAL_HELD = 2'd2    // flush in force while the request stays low
    } qual_state_e;

endpackage

// File: rtl/rxq_rst_qual.sv
module rxq_rst_qual
    import rxq_pkg::*;
#(
    parameter int unsigned QUAL_CYCLES = RXQ_QUAL_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req_n,
    input  logic bypass,
    input  logic rd_en,
    input  logic host_sel_n,
    output logic flush_now,
    output logic in_flush
);

    localparam int unsigned CNT_W = (QUAL_CYCLES < 2) ? 1 : $clog2(QUAL_CYCLES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(QUAL_CYCLES - 1);

    typedef struct packed {
        qual_state_e      st;
        logic [CNT_W-1:0] cnt;
    } qual_t;

    qual_t s_d, s_q;
    logic  qualify;

    always_comb begin
        s_d       = s_q;
        flush_now = 1'b0;
        qualify   = !flush_req_n && !bypass && !rd_en && !host_sel_n;
        case (s_q.st)
            QUAL_HELD: begin
                if (flush_req_n) begin
                    s_d.st = QUAL_IDLE;
                end else begin
                    flush_now = 1'b1;
                end
                s_d.cnt = '0;
            end
            default: begin
                if (qualify) begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.st    = QUAL_HELD;
                        s_d.cnt   = '0;
                        flush_now = 1'b1;
                    end else begin
                        s_d.st  = QUAL_ARM;
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end else begin
                    s_d.st  = QUAL_IDLE;
                    s_d.cnt = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: QUAL_IDLE, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_flush = (s_q.st == QUAL_HELD);

endmodule

// File: rtl/rxq_fifo_core.sv
module rxq_fifo_core #(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full
);

    localparam int unsigned PTR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             cnt;
    } core_t;

    core_t s_d, s_q;
    logic  push, pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        s_d  = s_q;
        push = wr_en && (s_q.cnt != CNT_FULL) && !flush;
        pop  = rd_en && (s_q.cnt != '0) && !flush;
        if (flush) begin
            s_d.wr_ptr = '0;
            s_d.rd_ptr = '0;
            s_d.cnt    = '0;
        end else begin
            if (push) begin
                s_d.mem[s_q.wr_ptr] = wr_data;
                s_d.wr_ptr          = ptr_next(s_q.wr_ptr);
            end
            if (pop) begin
                s_d.rd_ptr = ptr_next(s_q.rd_ptr);
            end
            case ({push, pop})
                2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
                2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.mem[s_q.rd_ptr];
    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == CNT_FULL);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W      = RXQ_DATA_W,
    parameter int unsigned DEPTH       = RXQ_DEPTH,
    parameter int unsigned QUAL_CYCLES = RXQ_QUAL_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    input  logic              host_sel_n,
    input  logic              bypass,
    input  logic              flush_req_n
);

    logic flush_now;
    logic in_flush;

    rxq_rst_qual #(
        .QUAL_CYCLES(QUAL_CYCLES)
    ) qual_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_req_n(flush_req_n),
        .bypass     (bypass),
        .rd_en      (rd_en),
        .host_sel_n (host_sel_n),
        .flush_now  (flush_now),
        .in_flush   (in_flush)
    );

    rxq_fifo_core #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush_now),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_data(rd_data),
        .empty  (empty),
        .full   (full)
    );

endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
    parameter int unsigned DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              bypass,
    input logic              flush_req_n,
    input logic              empty,
    input logic              full,
    input logic [DATA_W-1:0] rd_data,
    input logic              in_flush
);

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));                                                    // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && flush_req_n) |=> (full && $stable(rd_data))); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> empty);                                // R4

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_flush) |-> (empty && !full));                                // R7

    AST_HOLD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flush && !flush_req_n) |=> empty);                                // R8

    AST_BYPASS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !empty && !rd_en) |=> !empty);                             // R10

endmodule

bind rxq_fifo rxq_fifo_chk #(
    .DATA_W(DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .bypass     (bypass),
    .flush_req_n(flush_req_n),
    .empty      (empty),
    .full       (full),
    .rd_data    (rd_data),
    .in_flush   (in_flush)
);

// File: tb/rxq_fifo_tb_top.sv
`timescale 1ns/1ps
module rxq_fifo_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [9:0] rd_data;
    logic       empty, full;
    logic       host_sel_n = 1'b1;
    logic       bypass = 1'b0;
    logic       flush_req_n = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rxq_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
        .host_sel_n(host_sel_n), .bypass(bypass), .flush_req_n(flush_req_n)
    );

    typedef struct packed {
        logic       wr;
        logic [9:0] d;
        logic       rd;
        logic       e_empty;
        logic       e_full;
        logic       chk_data;
        logic [9:0] e_data;
    } vec_t;

    // Queue ordering vectors, applied from an empty queue (R2, R4)
    localparam vec_t VECS [10] = '{
        '{1'b1, 10'h155, 1'b0, 1'b0, 1'b0, 1'b1, 10'h155},
        '{1'b1, 10'h2AA, 1'b0, 1'b0, 1'b0, 1'b1, 10'h155},
        '{1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 1'b1, 10'h2AA},
        '{1'b1, 10'h001, 1'b1, 1'b0, 1'b0, 1'b1, 10'h001},
        '{1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 1'b0, 10'h000},
        '{1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 1'b0, 10'h000},
        '{1'b1, 10'h3FF, 1'b1, 1'b0, 1'b0, 1'b1, 10'h3FF},
        '{1'b1, 10'h0F0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h3FF},
        '{1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 1'b1, 10'h0F0},
        '{1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 1'b0, 10'h000}
    };

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle of inputs, then sample 1 ns after the rising edge
    task automatic step(input logic wr, input logic [9:0] d, input logic rd,
                        input logic sel_n, input logic byp, input logic req_n);
        wr_en = wr; wr_data = d; rd_en = rd;
        host_sel_n = sel_n; bypass = byp; flush_req_n = req_n;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, 10'h0, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic push(input logic [9:0] d);
        step(1'b1, d, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic req_low(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 10'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 empty after reset", {9'b0, empty}, 10'd1);
        check("R1 full after reset", {9'b0, full}, 10'd0);
        rst_n = 1'b1;
        idle();

        // Vector table: ordering, simultaneous push/pop, empty reads
        for (int v = 0; v < 10; v++) begin
            step(VECS[v].wr, VECS[v].d, VECS[v].rd, 1'b1, 1'b0, 1'b1);
            check($sformatf("R2/R4 vec%0d empty", v), {9'b0, empty}, {9'b0, VECS[v].e_empty});
            check($sformatf("R2/R4 vec%0d full", v), {9'b0, full}, {9'b0, VECS[v].e_full});
            if (VECS[v].chk_data)
                check($sformatf("R2 vec%0d data", v), rd_data, VECS[v].e_data);
        end

        // R3: fill to 16, dropped write, drain in order
        for (int i = 0; i < 16; i++) begin
            push(10'((i * 37 + 5) & 10'h3FF));
            if (i == 14) check("R3 not full at 15", {9'b0, full}, 10'd0);
        end
        check("R3 full at 16", {9'b0, full}, 10'd1);
        push(10'h111);
        check("R3 full after dropped write", {9'b0, full}, 10'd1);
        step(1'b1, 10'h222, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R3 write with read while full dropped", {9'b0, full}, 10'd0);
        for (int i = 1; i < 16; i++) begin
            check($sformatf("R3 drain %0d", i), rd_data, 10'((i * 37 + 5) & 10'h3FF));
            step(1'b0, 10'h0, 1'b1, 1'b1, 1'b0, 1'b1);
        end
        check("R3 empty after drain", {9'b0, empty}, 10'd1);

        // R5/R7/R8/R9: seventh qualifying sample flushes
        push(10'h0A1); push(10'h0A2); push(10'h0A3);
        req_low(6);
        check("R5 no flush after six", {9'b0, empty}, 10'd0);
        check("R5 head intact after six", rd_data, 10'h0A1);
        req_low(1);
        check("R5 R7 empty after seventh", {9'b0, empty}, 10'd1);
        check("R7 full cleared", {9'b0, full}, 10'd0);
        step(1'b1, 10'h1B1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 write rejected while held", {9'b0, empty}, 10'd1);
        step(1'b1, 10'h1B2, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R8 write rejected with gates off", {9'b0, empty}, 10'd1);
        idle();
        check("R9 empty after release", {9'b0, empty}, 10'd1);
        push(10'h2C3);
        check("R9 empty clears on write", {9'b0, empty}, 10'd0);
        check("R9 written data shown", rd_data, 10'h2C3);

        // R6: break by host deselect
        req_low(6);
        step(1'b0, 10'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        req_low(6);
        check("R6 sel break restarts count", {9'b0, empty}, 10'd0);
        req_low(1);
        check("R6 fresh seventh flushes", {9'b0, empty}, 10'd1);
        idle();

        // R6: break by request high
        push(10'h301);
        req_low(6);
        idle();
        req_low(6);
        check("R6 request-high break restarts", {9'b0, empty}, 10'd0);
        check("R6 data kept", rd_data, 10'h301);
        idle();

        // R6: break by a read
        push(10'h302); push(10'h303);
        req_low(6);
        step(1'b0, 10'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        req_low(6);
        check("R6 read break restarts", {9'b0, empty}, 10'd0);
        check("R6 read popped head", rd_data, 10'h302);
        idle();

        // R10: bypass blocks the request
        for (int i = 0; i < 20; i++) step(1'b0, 10'h0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R10 bypass ignores request", {9'b0, empty}, 10'd0);
        check("R10 data intact", rd_data, 10'h302);
        req_low(7);
        check("R10 flush once bypass drops", {9'b0, empty}, 10'd1);
        idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule